// File: doc/BRIEF.md
# Dual-Protocol Microprocessor Bus Adapter

This block connects an asynchronous 8-bit microprocessor bus to a synchronous register request interface. It supports two non-multiplexed bus styles, chosen by a static mode input. In mode 0 the host uses a chip select and two active-low strobes, one for reads and one for writes, and the block returns a ready indication. In mode 1 the host uses a chip select, one active-low data strobe and a direction line, and the block returns a data acknowledge. Both indications share one handshake output. That output is an open-drain pull-down enable: 1 means the line is pulled low, and 0 means the line floats.

All bus inputs pass through a two-stage synchronizer. An access starts on the synchronized rising edge of the active strobe, qualified by chip select. At that edge the block captures the address, the write data and the direction, and then raises a request. The request stays up until the back end returns a one-cycle completion pulse. Read data from the completion is placed on the data output, and its output enable stays active for as long as the host keeps the strobe asserted.

Top module: `mpbus_adapter`

## Requirements
- R1: In mode 0 (`mode_sel`=0), pulling `bus_strobe_n` low while `bus_ctl` is high and `bus_sel_n` is low issues a request with `req_write`=0 and `req_addr` equal to `bus_addr`.
- R2: In mode 0, pulling `bus_ctl` low (the write strobe) while `bus_sel_n` is low issues a request with `req_write`=1, and with `req_addr` and `req_wdata` equal to `bus_addr` and `bus_din`.
- R3: In mode 1 (`mode_sel`=1), a falling `bus_strobe_n` while `bus_sel_n` is low starts an access. Its direction is taken from `bus_ctl` at that moment: 1 means read and 0 means write.
- R4: Each access produces exactly one request. `req_valid` rises on the third rising clock edge after the strobe is asserted with stable inputs. It then holds, with `req_addr`, `req_write` and `req_wdata` unchanged, until the edge that samples `req_done`=1.
- R5: In mode 0, `hs_pull` is 1 from the start of the access until completion. It is 0 from the completion edge onward, even while the strobe is still asserted.
- R6: In mode 1, `hs_pull` is 0 while the request is pending. It becomes 1 at completion and stays 1 until the deasserted data strobe has passed the synchronizer.
- R7: While `bus_sel_n` is high, strobe activity starts no access: `req_valid` and `hs_pull` stay 0.
- R8: After a read completes, `bus_dout` carries `req_rdata` and `bus_dout_oe` is 1 while the strobe stays asserted. `bus_dout_oe` returns to 0 once the strobe is released.
- R9: With `bus_sel_n` held low, each new strobe pulse is a separate access with its own newly captured address.
- R10: If the strobe is removed before completion, the request still stays up until `req_done`. No pull and no output enable follow completion, and no second request is issued without a new strobe edge.
- R11: During reset and directly after it, `req_valid`, `hs_pull` and `bus_dout_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Static bus style: 0 selects separate strobes, 1 selects data strobe with direction line |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_strobe_n | input | 1 | Mode 0: read strobe; mode 1: data strobe (both active low) |
| bus_ctl | input | 1 | Mode 0: write strobe, active low; mode 1: direction, 1 = read |
| bus_addr | input | AW | External register address |
| bus_din | input | DW | Write data from the host |
| bus_dout | output | DW | Read data toward the host |
| bus_dout_oe | output | 1 | Enable for driving `bus_dout` |
| hs_pull | output | 1 | Pull-down enable for the open-drain handshake line |
| req_valid | output | 1 | Back-end request pending |
| req_write | output | 1 | Request direction, 1 = write |
| req_addr | output | AW | Request address |
| req_wdata | output | DW | Request write data |
| req_done | input | 1 | One-cycle completion pulse from the back end |
| req_rdata | input | DW | Read data, valid together with `req_done` |

## Verification
The hardest case to reach is a strobe released before the back end answers. In that case the handshake and the data enable must stay quiet after completion, and no second request may appear. The bench reaches it by releasing the strobe as soon as the request is seen and holding back the completion for several cycles, in both modes. Chip select stays low through whole address sweeps so that back-to-back pulses are exercised. Separate phases pulse the strobes while chip select is high.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_HOLD} ctl_state_t;

  // Active-high "access strobe asserted" after decoding the bus style.
  function automatic logic strobe_active(logic mode, logic sel_n, logic strobe_n, logic ctl);
    if (sel_n) return 1'b0;
    if (mode) return !strobe_n;
    return !strobe_n || !ctl;
  endfunction

  // Mode 0: a low write strobe; mode 1: a low direction line. Both mean write.
  function automatic logic access_is_write(logic ctl);
    return !ctl;
  endfunction
endpackage

// File: rtl/mpbus_sync.sv
module mpbus_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= RST_VAL;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= RST_VAL;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/mpbus_detect.sv
module mpbus_detect
  import mpbus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic sel_n,
  input  logic strobe_n,
  input  logic ctl,
  output logic act,
  output logic act_rise,
  output logic is_write
);
  logic act_q;

  assign act      = strobe_active(mode, sel_n, strobe_n, ctl);
  assign is_write = access_is_write(ctl);
  assign act_rise = act && !act_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
endmodule

// File: rtl/mpbus_ctrl.sv
module mpbus_ctrl
  import mpbus_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,
  input  logic          act,
  input  logic          act_rise,
  input  logic          is_write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          req_done,
  input  logic [DW-1:0] req_rdata,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          hs_pull,
  output logic          start_evt,
  output logic          done_evt
);
  ctl_state_t state, state_nx;

  assign start_evt = (state == ST_IDLE) && act_rise;
  assign done_evt  = (state == ST_BUSY) && req_done;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start_evt) state_nx = ST_BUSY;
      ST_BUSY: if (req_done)  state_nx = ST_HOLD;
      ST_HOLD: if (!act)      state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      dout      <= '0;
    end else begin
      state <= state_nx;
      if (start_evt) begin
        req_write <= is_write;
        req_addr  <= addr;
        req_wdata <= din;
      end
      if (done_evt && !req_write) dout <= req_rdata;
    end

  assign req_valid = (state == ST_BUSY);
  assign dout_oe   = (state == ST_HOLD) && act && !req_write;
  assign hs_pull   = mode ? ((state == ST_HOLD) && act) : (state == ST_BUSY);
endmodule

// File: rtl/mpbus_adapter.sv
module mpbus_adapter #(
  parameter int AW = 3,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          bus_sel_n,
  input  logic          bus_strobe_n,
  input  logic          bus_ctl,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_oe,
  output logic          hs_pull,
  output logic          req_valid,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_wdata,
  input  logic          req_done,
  input  logic [DW-1:0] req_rdata
);
  localparam int SW = 3 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {3'b111, {(AW+DW){1'b0}}};

  logic [SW-1:0] sync_q;
  logic          sync_sel_n, sync_strobe_n, sync_ctl;
  logic [AW-1:0] sync_addr;
  logic [DW-1:0] sync_din;
  logic          access_act, access_rise, access_wr;
  logic          start_evt, done_evt;

  mpbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({bus_sel_n, bus_strobe_n, bus_ctl, bus_addr, bus_din}),
    .q (sync_q)
  );

  assign {sync_sel_n, sync_strobe_n, sync_ctl, sync_addr, sync_din} = sync_q;

  mpbus_detect u_detect (
    .clk (clk),
    .rst_n (rst_n),
    .mode (mode_sel),
    .sel_n (sync_sel_n),
    .strobe_n (sync_strobe_n),
    .ctl (sync_ctl),
    .act (access_act),
    .act_rise (access_rise),
    .is_write (access_wr)
  );

  mpbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .mode (mode_sel),
    .act (access_act),
    .act_rise (access_rise),
    .is_write (access_wr),
    .addr (sync_addr),
    .din (sync_din),
    .req_done (req_done),
    .req_rdata (req_rdata),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr (req_addr),
    .req_wdata (req_wdata),
    .dout (bus_dout),
    .dout_oe (bus_dout_oe),
    .hs_pull (hs_pull),
    .start_evt (start_evt),
    .done_evt (done_evt)
  );
endmodule

// File: rtl/mpbus_adapter_chk.sv
module mpbus_adapter_chk #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_sel,
  input logic          sync_sel_n,
  input logic          start_evt,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [DW-1:0] req_wdata,
  input logic          req_done,
  input logic          hs_pull,
  input logic          bus_dout_oe
);
  assert_start_from_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(start_evt));

  assert_valid_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done |=> req_valid);

  assert_req_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_done |=> $stable(req_addr) && $stable(req_write) && $stable(req_wdata));

  assert_ready_during_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel && req_valid |-> hs_pull);

  assert_ack_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel && hs_pull |-> !req_valid);

  assert_start_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !sync_sel_n);

  assert_oe_only_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_oe |-> !req_valid && !req_write);

  assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_valid) |=> !req_valid);
endmodule

bind mpbus_adapter mpbus_adapter_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .mode_sel (mode_sel),
  .sync_sel_n (sync_sel_n),
  .start_evt (start_evt),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_addr (req_addr),
  .req_wdata (req_wdata),
  .req_done (req_done),
  .hs_pull (hs_pull),
  .bus_dout_oe (bus_dout_oe)
);

// File: tb/mpbus_adapter_test.sv
module mpbus_adapter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       bus_sel_n = 1'b1;
  logic       bus_strobe_n = 1'b1;
  logic       bus_ctl = 1'b1;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic       bus_dout_oe, hs_pull, req_valid, req_write;
  logic [2:0] req_addr;
  logic [7:0] req_wdata;
  logic       req_done = 1'b0;
  logic [7:0] req_rdata = '0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  mpbus_adapter uut (
    .clk (clk), .rst_n (rst_n), .mode_sel (mode_sel), .bus_sel_n (bus_sel_n),
    .bus_strobe_n (bus_strobe_n), .bus_ctl (bus_ctl), .bus_addr (bus_addr),
    .bus_din (bus_din), .bus_dout (bus_dout), .bus_dout_oe (bus_dout_oe),
    .hs_pull (hs_pull), .req_valid (req_valid), .req_write (req_write),
    .req_addr (req_addr), .req_wdata (req_wdata), .req_done (req_done),
    .req_rdata (req_rdata)
  );

  function automatic logic [7:0] rd_pattern(logic [2:0] a);
    return 8'((int'(a) * 29 + 7) % 256);
  endfunction

  function automatic logic [7:0] wr_pattern(logic [2:0] a, bit m);
    return 8'(((int'(a) * 53) % 256) ^ (m ? 8'h3C : 8'hA5));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic release_strobe(bit m);
    bus_strobe_n = 1'b1;
    if (!m) bus_ctl = 1'b1;
  endtask

  task automatic do_access(bit m, bit wr, logic [2:0] a, int dly, bit early);
    string dtag;
    int n;
    dtag = m ? "R3" : (wr ? "R2" : "R1");
    @(negedge clk);
    bus_addr = a;
    bus_din  = wr_pattern(a, m);
    if (!m) begin
      if (wr) bus_ctl = 1'b0; else bus_strobe_n = 1'b0;
    end else begin
      bus_ctl = !wr;
      bus_strobe_n = 1'b0;
    end
    n = 0;
    while (!req_valid && n < 20) begin @(posedge clk); #1; n++; end
    check("R4 request latency", n, 3);
    check({dtag, " direction"}, int'(req_write), int'(wr));
    check({"R9 ", dtag, " address"}, int'(req_addr), int'(a));
    if (wr) check({dtag, " write data"}, int'(req_wdata), int'(wr_pattern(a, m)));
    if (!m) check("R5 ready low while pending", int'(hs_pull), 1);
    else    check("R6 no ack while pending", int'(hs_pull), 0);
    if (early) begin @(negedge clk); release_strobe(m); end
    repeat (dly) @(posedge clk);
    #1 check(early ? "R10 request held after release" : "R4 request held", int'(req_valid), 1);
    @(negedge clk);
    req_done  = 1'b1;
    req_rdata = rd_pattern(a);
    @(posedge clk);
    #1 req_done = 1'b0;
    check("R4 request dropped at completion", int'(req_valid), 0);
    if (!m) check("R5 ready released at completion", int'(hs_pull), 0);
    else if (early) check("R10 no ack after early release", int'(hs_pull), 0);
    else check("R6 ack at completion", int'(hs_pull), 1);
    if (!wr && !early) begin
      check("R8 read enable", int'(bus_dout_oe), 1);
      check("R8 read data", int'(bus_dout), int'(rd_pattern(a)));
    end
    if (early) check("R10 no enable after early release", int'(bus_dout_oe), 0);
    repeat (3) @(posedge clk);
    #1 check(early ? "R10 single request" : "R4 single request", int'(req_valid), 0);
    if (m && !early) check("R6 ack held while strobe", int'(hs_pull), 1);
    if (!early) begin
      @(negedge clk);
      release_strobe(m);
      repeat (4) @(posedge clk);
      #1;
      check(m ? "R6 ack released" : "R5 ready stays released", int'(hs_pull), 0);
      check("R8 enable off after release", int'(bus_dout_oe), 0);
    end
    check("R9 idle between accesses", int'(req_valid), 0);
  endtask

  task automatic unselected_pulse(bit m);
    bit seen;
    seen = 1'b0;
    @(negedge clk);
    bus_sel_n = 1'b1;
    bus_strobe_n = 1'b0;
    if (!m) bus_ctl = 1'b0;
    repeat (6) begin
      @(posedge clk); #1;
      if (req_valid || hs_pull) seen = 1'b1;
    end
    @(negedge clk);
    bus_strobe_n = 1'b1;
    bus_ctl = 1'b1;
    repeat (4) @(posedge clk);
    #1 check("R7 no access without select", int'(seen), 0);
    @(negedge clk);
    bus_sel_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 check("R7 no access on select only", int'(req_valid), 0);
  endtask

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset valid", int'(req_valid), 0);
    check("R11 reset pull", int'(hs_pull), 0);
    check("R11 reset enable", int'(bus_dout_oe), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 idle valid", int'(req_valid), 0);
    check("R11 idle pull", int'(hs_pull), 0);
    unselected_pulse(1'b0);
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      bus_ctl = 1'b1;
      bus_strobe_n = 1'b1;
      mode_sel = m[0];
      bus_sel_n = 1'b0;
      repeat (4) @(posedge clk);
      for (int wr = 0; wr < 2; wr++)
        for (int a = 0; a < 8; a++)
          do_access(m[0], wr[0], 3'(a), a % 4, 1'b0);
      do_access(m[0], 1'b0, 3'd5, 6, 1'b1);
      do_access(m[0], 1'b1, 3'd2, 4, 1'b1);
      @(negedge clk) bus_ctl = 1'b1;
      unselected_pulse(m[0]);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule